// File: doc/BRIEF.md
# Receive Descriptor Engine

The engine takes frames from a byte-stream source and moves them into system memory under the control of a ring of receive descriptors. Each descriptor is a pair of words in a descriptor RAM. The even word holds the status and length, and the odd word holds the byte address of the receive buffer. The receive ring starts at a configurable index, just after the transmit descriptors, and runs to the end of the RAM.

Once receive is enabled, the engine waits for a descriptor whose ready bit is set. It then takes one frame and drops it if the destination address does not match the station address, unless promiscuous mode is on. Accepted bytes go to the buffer as 32-bit big-endian words. At the end of the frame the engine writes the length and status flags back into the descriptor, pulses an event and moves to the next descriptor. A frame that arrives while no descriptor is ready is discarded and raises a busy event.

Top module: `rxbd_engine`

## Requirements
- R1: With `rx_en` low the engine stays idle and does not accept input bytes (`in_ready` low), unless it is still discarding the tail of a dropped frame. When it is waiting for a descriptor with none ready and `rx_en` falls, it returns to idle.
- R2: A descriptor is ready when bit 15 of its status word (at index `bd_rd_idx`) is set. The buffer byte address is the word at index+1. On acceptance, status bits 7, 6, 5, 4, 3, 2 and 0 (miss, overrun, invalid, dribble, too-big, too-short, collision) are cleared. All other bits below 16, apart from ready, are written back unchanged.
- R3: When a frame arrives while `rx_en` is high and the current descriptor is not ready, the whole frame is consumed and discarded. `ev_busy` pulses once for that frame, and `irq_req` pulses with it when `mask_busy` is high.
- R4: Unless `promisc` is high, received bytes 0 to 5 must equal `station_addr[47:40]`, `[39:32]`, ... `[7:0]` in that order. On a mismatch the rest of the frame is discarded, no write-back occurs and the same descriptor serves the next frame.
- R5: A frame of fewer than 14 bytes gets no descriptor write-back and does not advance the index.
- R6: Byte k of a frame lands in the word at buffer address + 4*floor(k/4), lane k mod 4. Lane 0 is bits 31:24 and lane 3 is bits 7:0. Each word is written once, after its fourth byte or after the last byte of the frame.
- R7: When the frame length is not a multiple of four, the unused low lanes of the last word are zero. The stored length is the true byte count.
- R8: At the end of an accepted frame, the status word is written back with the length in bits 31:16 and bit 15 (ready) cleared, and `ev_rxb` pulses for one cycle.
- R9: The write-back sets bit 2 (too-short) when the length is below `min_len`, and bit 3 (too-big) when it is above `max_len`.
- R10: After reset the index equals `rx_ring_base`. After a write-back it becomes `rx_ring_base` if status bit 13 (wrap) is set or the index is at least BD_WORDS-2; otherwise it becomes index+2.
- R11: `irq_req` pulses together with `ev_rxb` when `mask_rxb` is high, and stays low for that event when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| promisc | input | 1 | Accept any destination address |
| station_addr | input | 48 | Station address, bits 47:40 compared with the first byte |
| min_len | input | LEN_W | Minimum frame length for the too-short flag |
| max_len | input | LEN_W | Maximum frame length for the too-big flag |
| rx_ring_base | input | IDX_W | First descriptor index of the receive ring (even) |
| mask_rxb | input | 1 | Enable interrupt on frame received |
| mask_busy | input | 1 | Enable interrupt on busy |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Byte value |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Byte is taken at this clock edge |
| mem_we | output | 1 | Buffer word write strobe |
| mem_addr | output | ADDR_W | Buffer word byte address |
| mem_wdata | output | 32 | Buffer word data |
| bd_rd_idx | output | IDX_W | Current descriptor index |
| bd_stat_in | input | 32 | Status word at the current index |
| bd_ptr_in | input | ADDR_W | Buffer address word at index+1 |
| bd_wr_en | output | 1 | Status write-back strobe |
| bd_wr_idx | output | IDX_W | Index of the status word written |
| bd_wr_data | output | 32 | Status word written back |
| ev_rxb | output | 1 | Frame received event pulse |
| ev_busy | output | 1 | Frame lost for want of a descriptor |
| irq_req | output | 1 | Interrupt request pulse |

## Verification
The frame lengths used are 14, 16, 22 and 24 bytes (whole and partial last words), a 10-byte runt and a 70-byte oversize frame, so padding, length flags and the runt drop can each be told apart. Frames with a corrupted destination byte are sent once with filtering on and once with promiscuous mode on. The first must leave the descriptor and memory untouched, and the second must store the corrupted byte as received. The ring is walked through a normal step, the end-of-region limit and the wrap bit, each confirmed through the index port. Busy frames are sent with the busy mask on and off, and a final frame is sent with the receive mask off, so that event pulses can be told apart from interrupt requests.

// File: rtl/rxbd_pkg.sv
// Shared types and the descriptor status word layout of the receive engine.
package rxbd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAITBD = 2'd1,
        ST_RECV   = 2'd2,
        ST_FINISH = 2'd3
    } rx_state_e;

    localparam int BIT_READY    = 15;
    localparam int BIT_WRAP     = 13;
    localparam int BIT_MISS     = 7;
    localparam int BIT_OVERRUN  = 6;
    localparam int BIT_INVALID  = 5;
    localparam int BIT_DRIBBLE  = 4;
    localparam int BIT_TOOBIG   = 3;
    localparam int BIT_TOOSHORT = 2;
    localparam int BIT_COLL     = 0;

    localparam int HDR_BYTES  = 14;
    localparam int ADDR_BYTES = 6;

    // Status bits that are cleared when a descriptor is taken.
    localparam logic [31:0] ACCEPT_CLEAR =
        (32'd1 << BIT_MISS) | (32'd1 << BIT_OVERRUN) | (32'd1 << BIT_INVALID) |
        (32'd1 << BIT_DRIBBLE) | (32'd1 << BIT_TOOBIG) | (32'd1 << BIT_TOOSHORT) |
        (32'd1 << BIT_COLL);
endpackage

// File: rtl/rxbd_addr_match.sv
// Destination address filter.
// Checks one header byte against the station address byte that it must
// equal. Assumes the byte position is the count of bytes already taken
// in the current frame. Positions at and beyond the address field always pass.
module rxbd_addr_match
    import rxbd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [47:0]      station_addr,
    input  logic             promisc,
    input  logic [LEN_W-1:0] byte_pos,
    input  logic [7:0]       byte_in,
    output logic             byte_ok
);
    logic [7:0] exp_byte [0:7];

    // Byte k of the frame is compared with station byte 5-k (most significant first).
    for (genvar k = 0; k < 8; k++) begin : g_lane
        if (k < ADDR_BYTES) begin : g_addr
            assign exp_byte[k] = station_addr[8*(ADDR_BYTES-1-k) +: 8];
        end else begin : g_pad
            assign exp_byte[k] = 8'd0;
        end
    end

    // Pass-through in promiscuous mode or past the address field.
    always_comb begin
        if (promisc || (byte_pos >= LEN_W'(ADDR_BYTES)))
            byte_ok = 1'b1;
        else
            byte_ok = (byte_in == exp_byte[byte_pos[2:0]]);
    end
endmodule

// File: rtl/rxbd_word_pack.sv
// Byte-to-word packer and buffer write port.
// Collects bytes into big-endian 32-bit words and issues one registered write
// per word, after lane 3 or after the frame's last byte. Assumes the byte count
// restarts at zero for each frame, so lane 0 always opens a fresh word.
module rxbd_word_pack #(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              flush,
    input  logic [LEN_W-1:0]  byte_cnt,
    input  logic [7:0]        byte_in,
    input  logic [ADDR_W-1:0] base_ptr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata
);
    logic [1:0]       lane;
    logic [31:0]      wbuf;
    logic [31:0]      merged;
    logic [LEN_W-1:0] word_off;
    logic             emit;

    assign lane     = byte_cnt[1:0];
    assign word_off = {byte_cnt[LEN_W-1:2], 2'b00};
    assign emit     = take && ((lane == 2'd3) || flush);

    // Insert the new byte into its lane; lane 0 starts from an all-zero word.
    always_comb begin
        merged = (lane == 2'd0) ? 32'd0 : wbuf;
        for (int l = 0; l < 4; l++) begin
            if (lane == 2'(l))
                merged[(3-l)*8 +: 8] = byte_in;
        end
    end

    // Hold the partial word and register the outgoing write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbuf      <= 32'd0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= 32'd0;
        end else begin
            mem_we <= emit;
            if (take)
                wbuf <= merged;
            if (emit) begin
                mem_wdata <= merged;
                mem_addr  <= base_ptr + ADDR_W'(word_off);
            end
        end
    end

    a_r6_full_word_written: assert property (@(posedge clk) disable iff (!rst_n)
        (take && lane == 2'd3) |=> mem_we);

    a_r7_last_word_padded: assert property (@(posedge clk) disable iff (!rst_n)
        (take && flush && lane == 2'd0) |=> (mem_we && mem_wdata[23:0] == 24'd0));
endmodule

// File: rtl/rxbd_status_fmt.sv
// Write-back status word builder.
// Combines the captured descriptor status (with its error flags already
// cleared) with the frame length and the length-limit flags, and clears the
// ready bit. Assumes LEN_W is at most 16 so the length fits bits 31:16.
module rxbd_status_fmt
    import rxbd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [31:0]      stat_in,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [LEN_W-1:0] min_len,
    input  logic [LEN_W-1:0] max_len,
    output logic [31:0]      stat_out
);
    // Length field, ready release and limit flags.
    always_comb begin
        stat_out               = stat_in;
        stat_out[31:16]        = 16'(frame_len);
        stat_out[BIT_READY]    = 1'b0;
        stat_out[BIT_TOOSHORT] = (frame_len < min_len);
        stat_out[BIT_TOOBIG]   = (frame_len > max_len);
    end
endmodule

// File: rtl/rxbd_engine.sv
// Receive descriptor engine (top).
// Walks a ring of receive descriptors that starts at rx_ring_base, fills each
// buffer with one address-filtered frame, writes back the status and steps on.
// Assumes: the descriptor RAM answers reads combinationally; rx_ring_base is
// even and constant while enabled; buffer pointers are word aligned; frames are
// shorter than 2**LEN_W bytes.
module rxbd_engine
    import rxbd_pkg::*;
#(
    parameter int BD_WORDS = 128,
    parameter int LEN_W    = 16,
    parameter int ADDR_W   = 32,
    localparam int IDX_W   = $clog2(BD_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              promisc,
    input  logic [47:0]       station_addr,
    input  logic [LEN_W-1:0]  min_len,
    input  logic [LEN_W-1:0]  max_len,
    input  logic [IDX_W-1:0]  rx_ring_base,
    input  logic              mask_rxb,
    input  logic              mask_busy,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [IDX_W-1:0]  bd_rd_idx,
    input  logic [31:0]       bd_stat_in,
    input  logic [ADDR_W-1:0] bd_ptr_in,
    output logic              bd_wr_en,
    output logic [IDX_W-1:0]  bd_wr_idx,
    output logic [31:0]       bd_wr_data,
    output logic              ev_rxb,
    output logic              ev_busy,
    output logic              irq_req
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BD_WORDS - 2);

    rx_state_e         state;
    logic [IDX_W-1:0]  idx;
    logic              drop_q;
    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  cnt_nxt;
    logic [LEN_W-1:0]  len_q;
    logic [31:0]       stat_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              bd_ready;
    logic              hdr_ok;
    logic              take;
    logic              wrap_now;

    assign bd_ready = bd_stat_in[BIT_READY];
    assign cnt_nxt  = cnt + LEN_W'(1);
    assign take     = (state == ST_RECV) && in_valid;
    assign wrap_now = stat_q[BIT_WRAP] || (idx >= LAST_IDX);

    // Input handshake: discarding, receiving, or swallowing a busy frame.
    assign in_ready = drop_q || (state == ST_RECV) ||
                      ((state == ST_WAITBD) && rx_en && !bd_ready);

    assign ev_busy  = (state == ST_WAITBD) && !drop_q && rx_en && !bd_ready && in_valid;
    assign ev_rxb   = (state == ST_FINISH);
    assign irq_req  = (ev_rxb && mask_rxb) || (ev_busy && mask_busy);

    assign bd_rd_idx = idx;
    assign bd_wr_idx = idx;
    assign bd_wr_en  = (state == ST_FINISH);

    rxbd_addr_match #(.LEN_W(LEN_W)) u_match (
        .station_addr (station_addr),
        .promisc      (promisc),
        .byte_pos     (cnt),
        .byte_in      (in_data),
        .byte_ok      (hdr_ok)
    );

    rxbd_word_pack #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take && hdr_ok),
        .flush     (in_last),
        .byte_cnt  (cnt),
        .byte_in   (in_data),
        .base_ptr  (ptr_q),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    rxbd_status_fmt #(.LEN_W(LEN_W)) u_fmt (
        .stat_in   (stat_q),
        .frame_len (len_q),
        .min_len   (min_len),
        .max_len   (max_len),
        .stat_out  (bd_wr_data)
    );

    // Main sequencer: state, ring index, byte count and discard flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= rx_ring_base;
            drop_q <= 1'b0;
            cnt    <= '0;
            len_q  <= '0;
            stat_q <= 32'd0;
            ptr_q  <= '0;
        end else begin
            if (drop_q && in_valid)
                drop_q <= !in_last;
            case (state)
                ST_IDLE: begin
                    if (rx_en)
                        state <= ST_WAITBD;
                end
                ST_WAITBD: begin
                    if (!drop_q) begin
                        if (bd_ready) begin
                            stat_q <= bd_stat_in & ~ACCEPT_CLEAR;
                            ptr_q  <= bd_ptr_in;
                            cnt    <= '0;
                            state  <= ST_RECV;
                        end else if (!rx_en) begin
                            state <= ST_IDLE;
                        end else if (in_valid) begin
                            drop_q <= !in_last;
                        end
                    end
                end
                ST_RECV: begin
                    if (in_valid) begin
                        cnt <= cnt_nxt;
                        if (!hdr_ok) begin
                            drop_q <= !in_last;
                            state  <= ST_IDLE;
                        end else if (in_last) begin
                            len_q <= cnt_nxt;
                            state <= (cnt_nxt < LEN_W'(HDR_BYTES)) ? ST_IDLE : ST_FINISH;
                        end
                    end
                end
                ST_FINISH: begin
                    idx   <= wrap_now ? rx_ring_base : idx + IDX_W'(2);
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rx_en) |=> (state == ST_IDLE));

    a_r2_accept_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV && $past(state) == ST_WAITBD) |-> $past(bd_stat_in[BIT_READY]));

    a_r5_runt_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECV && in_valid && in_last && cnt < LEN_W'(HDR_BYTES - 1)) |=> !bd_wr_en);

    a_r8_ready_released: assert property (@(posedge clk) disable iff (!rst_n)
        bd_wr_en |-> !bd_wr_data[BIT_READY]);

    a_r10_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        bd_wr_en |=> (bd_rd_idx == rx_ring_base || bd_rd_idx == $past(bd_rd_idx) + IDX_W'(2)));
endmodule

// File: tb/rxbd_engine_test.sv
`timescale 1ns/1ps
module rxbd_engine_test;
    localparam int BDW  = 16;
    localparam int IDXW = 4;
    localparam logic [47:0] STA = 48'h0A1B2C3D4E5F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0, promisc = 1'b0;
    logic [15:0] min_len = 16'd20, max_len = 16'd64;
    logic        mask_rxb = 1'b1, mask_busy = 1'b1;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_data = 8'd0;
    logic        in_ready, mem_we, bd_wr_en, ev_rxb, ev_busy, irq_req;
    logic [31:0] mem_addr, mem_wdata, bd_wr_data, bd_stat_in, bd_ptr_in;
    logic [IDXW-1:0] bd_rd_idx, bd_wr_idx;

    logic [31:0] bd_mem [0:BDW-1];
    logic [63:0] mem_q [$];
    logic [63:0] bd_q [$];
    int n_checks = 0, n_fail = 0;
    int rxb_cnt = 0, busy_cnt = 0, irq_cnt = 0;

    always #10 clk = ~clk;

    assign bd_stat_in = bd_mem[bd_rd_idx];
    assign bd_ptr_in  = bd_mem[{bd_rd_idx[IDXW-1:1], 1'b1}];

    rxbd_engine #(.BD_WORDS(BDW), .LEN_W(16), .ADDR_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .promisc(promisc),
        .station_addr(STA), .min_len(min_len), .max_len(max_len),
        .rx_ring_base(4'd8), .mask_rxb(mask_rxb), .mask_busy(mask_busy),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .bd_rd_idx(bd_rd_idx), .bd_stat_in(bd_stat_in), .bd_ptr_in(bd_ptr_in),
        .bd_wr_en(bd_wr_en), .bd_wr_idx(bd_wr_idx), .bd_wr_data(bd_wr_data),
        .ev_rxb(ev_rxb), .ev_busy(ev_busy), .irq_req(irq_req)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected writes and compares, counts event pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (mem_q.size() == 0)
                    check(1'b0, "R6", "unexpected buffer write", {mem_addr, mem_wdata}, 64'd0);
                else begin
                    logic [63:0] e;
                    e = mem_q.pop_front();
                    check({mem_addr, mem_wdata} == e, "R6 R7", "buffer word", {mem_addr, mem_wdata}, e);
                end
            end
            if (bd_wr_en) begin
                bd_mem[bd_wr_idx] = bd_wr_data;
                if (bd_q.size() == 0)
                    check(1'b0, "R8", "unexpected write-back", {28'd0, bd_wr_idx, bd_wr_data}, 64'd0);
                else begin
                    logic [63:0] e;
                    e = bd_q.pop_front();
                    check({28'd0, bd_wr_idx, bd_wr_data} == e, "R2 R8 R9", "write-back",
                          {28'd0, bd_wr_idx, bd_wr_data}, e);
                end
            end
            if (ev_rxb)  rxb_cnt++;
            if (ev_busy) busy_cnt++;
            if (irq_req) irq_cnt++;
        end
    end

    // Driver: builds a frame, queues its expected effects, then streams it.
    task automatic do_frame(input int n, input int seed, input int bad_pos,
                            input bit exp_mem, input bit exp_bd,
                            input logic [31:0] ptr, input int idx, input logic [31:0] stat);
        logic [7:0] fb [$];
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = (i < 6) ? STA[8*(5-i) +: 8] : 8'(seed + i);
            if (i == bad_pos) b = ~b;
            fb.push_back(b);
        end
        if (exp_mem) begin
            for (int k = 0; 4*k < n; k++) begin
                logic [31:0] w;
                bit filtered;
                filtered = (bad_pos >= 0) && !promisc;
                if (!filtered || (4*k + 3 < bad_pos)) begin
                    for (int j = 0; j < 4; j++)
                        w[(3-j)*8 +: 8] = (4*k + j < n) ? fb[4*k + j] : 8'd0;
                    mem_q.push_back({ptr + 32'(4*k), w});
                end
            end
        end
        if (exp_bd) begin
            logic [31:0] e;
            e = {16'(n), stat[15:0] & ~16'h80FD};
            if (16'(n) < min_len) e[2] = 1'b1;
            if (16'(n) > max_len) e[3] = 1'b1;
            bd_q.push_back({28'd0, 4'(idx), e});
        end
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_data = fb[i]; in_last = (i == n - 1);
            forever begin
                @(negedge clk);
                if (in_ready) begin @(posedge clk); #1; break; end
            end
        end
        in_valid = 1'b0; in_last = 1'b0;
        repeat (4) begin @(posedge clk); #1; end
        check(mem_q.size() == 0, "R6", "buffer writes outstanding", 64'(mem_q.size()), 64'd0);
        check(bd_q.size() == 0, "R8", "write-backs outstanding", 64'(bd_q.size()), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < BDW; i++) bd_mem[i] = 32'd0;
        bd_mem[8]  = 32'hABCD_82FD; bd_mem[9]  = 32'h0000_0100;
        bd_mem[10] = 32'h1234_80FD; bd_mem[11] = 32'h0000_0200;
        bd_mem[12] = 32'h0000_8041; bd_mem[13] = 32'h0000_0300;
        bd_mem[14] = 32'h0000_80FC; bd_mem[15] = 32'h0000_0400;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(in_ready == 1'b0, "R1", "reset in_ready", 64'(in_ready), 64'd0);
        check(mem_we == 1'b0, "R6", "reset mem_we", 64'(mem_we), 64'd0);
        check(bd_wr_en == 1'b0, "R8", "reset bd_wr_en", 64'(bd_wr_en), 64'd0);
        check(bd_rd_idx == 4'd8, "R10", "reset index", 64'(bd_rd_idx), 64'd8);

        // R1: disabled engine ignores offered bytes even with a ready descriptor
        @(posedge clk); #1;
        in_valid = 1'b1; in_data = 8'h0A;
        begin
            bit seen;
            seen = 1'b0;
            repeat (5) begin @(negedge clk); if (in_ready) seen = 1'b1; end
            check(!seen, "R1", "in_ready while disabled", 64'(seen), 64'd0);
        end
        @(posedge clk); #1; in_valid = 1'b0;

        rx_en = 1'b1;
        do_frame(16, 3, -1, 1, 1, 32'h100, 8, 32'hABCD_82FD);   // R9 too-short
        do_frame(22, 7, -1, 1, 1, 32'h200, 10, 32'h1234_80FD);  // R7 padding
        do_frame(20, 5, 2, 1, 0, 32'h300, 12, 32'h0);           // R4 dropped
        check(bd_rd_idx == 4'd12, "R4", "index after filtered frame", 64'(bd_rd_idx), 64'd12);
        check(rxb_cnt == 2, "R4", "rxb count after filtered frame", 64'(rxb_cnt), 64'd2);
        promisc = 1'b1;
        do_frame(24, 9, 2, 1, 1, 32'h300, 12, 32'h0000_8041);   // R4 promiscuous
        promisc = 1'b0;
        do_frame(10, 1, -1, 1, 0, 32'h400, 14, 32'h0);          // R5 runt
        check(bd_rd_idx == 4'd14, "R5", "index after runt", 64'(bd_rd_idx), 64'd14);
        do_frame(70, 11, -1, 1, 1, 32'h400, 14, 32'h0000_80FC); // R9 too-big
        check(bd_rd_idx == 4'd8, "R10", "index wraps at region end", 64'(bd_rd_idx), 64'd8);

        bd_mem[8] = 32'h0000_A2FD;
        do_frame(14, 2, -1, 1, 1, 32'h100, 8, 32'h0000_A2FD);   // R5 boundary, R10 wrap bit
        check(bd_rd_idx == 4'd8, "R10", "index after wrap bit", 64'(bd_rd_idx), 64'd8);
        check(irq_cnt == 5, "R11", "irq count with rxb unmasked", 64'(irq_cnt), 64'd5);

        // R3: no ready descriptor
        do_frame(20, 4, -1, 0, 0, 32'h0, 8, 32'h0);
        check(busy_cnt == 1, "R3", "busy pulses per frame", 64'(busy_cnt), 64'd1);
        check(irq_cnt == 6, "R3", "busy irq unmasked", 64'(irq_cnt), 64'd6);
        mask_busy = 1'b0;
        do_frame(3, 4, -1, 0, 0, 32'h0, 8, 32'h0);
        check(busy_cnt == 2, "R3", "busy pulse masked frame", 64'(busy_cnt), 64'd2);
        check(irq_cnt == 6, "R3", "busy irq masked", 64'(irq_cnt), 64'd6);

        // R11: rxb masked
        mask_rxb = 1'b0; min_len = 16'd14;
        bd_mem[8] = 32'hABCD_82FD;
        do_frame(16, 8, -1, 1, 1, 32'h100, 8, 32'hABCD_82FD);
        check(rxb_cnt == 6, "R8", "rxb event count", 64'(rxb_cnt), 64'd6);
        check(irq_cnt == 6, "R11", "irq with rxb masked", 64'(irq_cnt), 64'd6);
        check(bd_rd_idx == 4'd10, "R10", "index steps by two", 64'(bd_rd_idx), 64'd10);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule